// File: doc/BRIEF.md
# Sixteen-pin GPIO bank with edge-triggered interrupts

This block is a bank of sixteen general-purpose pins controlled through a small 32-bit register bus. Each pin has a direction bit, an output data bit, an input sample taken after a two-stage synchronizer, a two-bit code that selects which edge raises an interrupt, an interrupt enable, and a status bit that stays set until software clears it. The bank drives a single interrupt line.

Software changes single bits of the output data or the interrupt enables without a read-modify-write. It does this by writing a mask to a set alias or a clear alias. It acknowledges interrupts by writing ones to the status register. A detected edge records status whether or not its pin is enabled, so the enable only gates the interrupt line. Pins whose direction bit is set are inputs; every other pin drives its output data onto the pad.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous reset, the bank is in this state:
  - interrupt enable is 0x0000;
  - status is 0x0000;
  - direction is 0xFFFF, so every pin is an input;
  - output data is 0;
  - both edge registers are 0;
  - `irq` is 0 and `pad_oe` is 0.
- R2: Reads and the revision register:
  - Read data appears on `bus_rdata` in the cycle after the one in which `bus_re` is high, and holds until the next read.
  - Offset 0x00 reads 0x00000021, with the major version 2 in bits 7:4 and the minor version 1 in bits 3:0.
  - An unmapped offset reads 0, and bits 31:16 always read 0.
- R3: The offsets 0x1C (interrupt enable), 0x30 (output data), 0x34 (direction), 0x38 (edge codes for pins 0-7) and 0x3C (edge codes for pins 8-15) store bits 15:0 of the write data. Each reads back what was written.
- R4: Output data aliases:
  - A write to 0xF0 sets every output-data bit that is 1 in the write data.
  - A write to 0xB0 clears every output-data bit that is 1 in the write data.
  - All other bits keep their value.
- R5: Interrupt-enable aliases:
  - A write to 0xDC sets every interrupt-enable bit that is 1 in the write data.
  - A write to 0x9C clears every interrupt-enable bit that is 1 in the write data.
  - All other bits keep their value.
- R6: Edge code fields and values:
  - Pin n below 8 uses bits [2n+1:2n] of offset 0x38. Pin n from 8 up uses bits [2(n-8)+1:2(n-8)] of offset 0x3C.
  - Code 0 selects no edge, and that pin never sets its status.
  - Code 1 selects the rising edge, code 2 the falling edge, and code 3 both edges.
- R7: Edges are taken from the synchronized input. A pad value present at clock edge k sets the matching status bit at clock edge k+2, whether or not that pin's interrupt is enabled.
- R8: The status register at 0x18 is cleared by writing ones:
  - Each 1 in the write data clears that status bit, and each 0 leaves its bit unchanged.
  - If an edge event and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: `irq` is a register that goes high one cycle after any bit is both set in status and enabled, and low one cycle after no such bit remains.
- R10: Pads and data in:
  - `pad_oe` is high exactly for the pins whose direction bit is 0.
  - `pad_out` carries output data on those pins and 0 on all other pins.
  - Offset 0x2C reads the synchronized pad value of every pin, whatever its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to reach from the ports is an edge event and a clear write that land on the same status bit in the same clock. The stimulus changes a pad at a known negative edge and counts the synchronizer and edge-detector stages. It then places the clear write so that the write's clock edge is the one where the status bit would be set, and checks that the bit stays set. Status set on masked pins is reached by arming different edge codes on several pins at once, with only some of those pins enabled.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFF_REV      = 8'h00;
    localparam logic [BUS_AW-1:0] OFF_ISTAT    = 8'h18;
    localparam logic [BUS_AW-1:0] OFF_IEN      = 8'h1C;
    localparam logic [BUS_AW-1:0] OFF_DIN      = 8'h2C;
    localparam logic [BUS_AW-1:0] OFF_DOUT     = 8'h30;
    localparam logic [BUS_AW-1:0] OFF_DIR      = 8'h34;
    localparam logic [BUS_AW-1:0] OFF_EDGE_LO  = 8'h38;
    localparam logic [BUS_AW-1:0] OFF_EDGE_HI  = 8'h3C;
    localparam logic [BUS_AW-1:0] OFF_IEN_CLR  = 8'h9C;
    localparam logic [BUS_AW-1:0] OFF_DOUT_CLR = 8'hB0;
    localparam logic [BUS_AW-1:0] OFF_IEN_SET  = 8'hDC;
    localparam logic [BUS_AW-1:0] OFF_DOUT_SET = 8'hF0;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic              we;
        logic              re;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    function automatic logic edge_hit(edge_mode_e mode, logic cur, logic prv);
        logic r;
        case (mode)
            EDGE_RISE: r = cur & ~prv;
            EDGE_FALL: r = ~cur & prv;
            EDGE_BOTH: r = cur ^ prv;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[s] <= '0;
                end else if (s == 0) begin
                    stage[s] <= d;
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPINS-1:0]   level,
    input  logic [2*NPINS-1:0] mode_bits,
    output logic [NPINS-1:0]   hit
);
    logic [NPINS-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= level;
    end

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            assign hit[i] = edge_hit(edge_mode_e'(mode_bits[2*i +: 2]), level[i], prev[i]);

            // R6: a pin with no edge selected reports no event
            a_r6_none_no_hit: assert property (@(posedge clk) disable iff (rst)
                (mode_bits[2*i +: 2] == 2'd0) |-> !hit[i]);
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int         NPINS     = 16,
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NPINS-1:0]   pin_level,
    input  logic [NPINS-1:0]   hit,
    output logic [2*NPINS-1:0] edge_bits,
    output logic [NPINS-1:0]   dir,
    output logic [NPINS-1:0]   dout,
    output logic [BUS_DW-1:0]  rdata,
    output logic               irq
);
    logic [NPINS-1:0]  ien;
    logic [NPINS-1:0]  status;
    logic [NPINS-1:0]  wmask;
    logic [NPINS-1:0]  clr_mask;
    logic [BUS_DW-1:0] rd_mux;

    assign wmask    = req.wdata[NPINS-1:0];
    assign clr_mask = (req.we && req.addr == OFF_ISTAT) ? wmask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien       <= '0;
            dout      <= '0;
            dir       <= '1;
            edge_bits <= '0;
        end else if (req.we) begin
            case (req.addr)
                OFF_IEN:      ien  <= wmask;
                OFF_IEN_SET:  ien  <= ien | wmask;
                OFF_IEN_CLR:  ien  <= ien & ~wmask;
                OFF_DOUT:     dout <= wmask;
                OFF_DOUT_SET: dout <= dout | wmask;
                OFF_DOUT_CLR: dout <= dout & ~wmask;
                OFF_DIR:      dir  <= wmask;
                OFF_EDGE_LO:  edge_bits[NPINS-1:0]       <= wmask;
                OFF_EDGE_HI:  edge_bits[2*NPINS-1:NPINS] <= wmask;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= (status & ~clr_mask) | hit;
            irq    <= |(status & ien);
        end
    end

    always_comb begin
        case (req.addr)
            OFF_REV:     rd_mux = BUS_DW'({REV_MAJOR, REV_MINOR});
            OFF_ISTAT:   rd_mux = BUS_DW'(status);
            OFF_IEN:     rd_mux = BUS_DW'(ien);
            OFF_DIN:     rd_mux = BUS_DW'(pin_level);
            OFF_DOUT:    rd_mux = BUS_DW'(dout);
            OFF_DIR:     rd_mux = BUS_DW'(dir);
            OFF_EDGE_LO: rd_mux = BUS_DW'(edge_bits[NPINS-1:0]);
            OFF_EDGE_HI: rd_mux = BUS_DW'(edge_bits[2*NPINS-1:NPINS]);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.re) rdata <= rd_mux;
    end

    // R4: set alias forces the masked output bits high
    a_r4_set_alias: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.addr == OFF_DOUT_SET) |=> ((dout & $past(wmask)) == $past(wmask)));

    // R5: clear alias forces the masked enable bits low
    a_r5_clr_alias: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.addr == OFF_IEN_CLR) |=> ((ien & $past(wmask)) == '0));

    // R8: write-one clears a bit that has no event in the same cycle
    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
        (|(clr_mask & ~hit)) |=> ((status & $past(clr_mask & ~hit)) == '0));

    // R8: an event always lands, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((status & $past(hit)) == $past(hit)));

    // R9: with all enables off the line is low next cycle
    a_r9_masked: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |=> !irq);
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    localparam int SYNC_STAGES = 2;

    bus_req_t           req;
    logic [NPINS-1:0]   level;
    logic [NPINS-1:0]   hit;
    logic [2*NPINS-1:0] edge_bits;
    logic [NPINS-1:0]   dir;
    logic [NPINS-1:0]   dout;

    assign req = '{addr: bus_addr, we: bus_we, re: bus_re, wdata: bus_wdata};

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(level)
    );

    gpio_edge_det #(.NPINS(NPINS)) u_edge (
        .clk(clk), .rst(rst), .level(level), .mode_bits(edge_bits), .hit(hit)
    );

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst(rst), .req(req), .pin_level(level), .hit(hit),
        .edge_bits(edge_bits), .dir(dir), .dout(dout), .rdata(bus_rdata), .irq(irq)
    );

    assign pad_oe  = ~dir;
    assign pad_out = dout & ~dir;

    // R10: an input pin never drives
    a_r10_no_drive_in: assert property (@(posedge clk) disable iff (rst)
        ((pad_out & ~pad_oe) == '0));
endmodule

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe;
    logic        irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    bit live    = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    gpio_edge_bank uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // behavioural reference
    logic [15:0] m_dout, m_dir, m_en, m_st, m_elo, m_ehi, m_s1, m_s2, m_prev;
    logic [31:0] m_rdata;
    logic        m_irq;
    string       m_rtag = "R1";

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00: return 32'h21;
            8'h18: return {16'h0, m_st};
            8'h1C: return {16'h0, m_en};
            8'h2C: return {16'h0, m_s2};
            8'h30: return {16'h0, m_dout};
            8'h34: return {16'h0, m_dir};
            8'h38: return {16'h0, m_elo};
            8'h3C: return {16'h0, m_ehi};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_dout = 0; m_dir = 16'hFFFF; m_en = 0; m_st = 0; m_elo = 0; m_ehi = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_rdata = 0; m_irq = 0;
        end else begin
            logic [15:0] ev, clr;
            ev = 0;
            for (int p = 0; p < 16; p++) begin
                int code;
                code = (p < 8) ? int'((m_elo >> (2*p)) & 3) : int'((m_ehi >> (2*(p-8))) & 3);
                if ((code == 1 || code == 3) && m_s2[p] && !m_prev[p]) ev[p] = 1;
                if ((code == 2 || code == 3) && !m_s2[p] && m_prev[p]) ev[p] = 1;
            end
            m_irq = (m_st & m_en) != 0;
            if (bus_re) begin m_rdata = m_read(bus_addr); m_rtag = cur_tag; end
            clr = 0;
            if (bus_we) begin
                case (bus_addr)
                    8'h18: clr = bus_wdata[15:0];
                    8'h1C: m_en = bus_wdata[15:0];
                    8'hDC: m_en = m_en | bus_wdata[15:0];
                    8'h9C: m_en = m_en & ~bus_wdata[15:0];
                    8'h30: m_dout = bus_wdata[15:0];
                    8'hF0: m_dout = m_dout | bus_wdata[15:0];
                    8'hB0: m_dout = m_dout & ~bus_wdata[15:0];
                    8'h34: m_dir = bus_wdata[15:0];
                    8'h38: m_elo = bus_wdata[15:0];
                    8'h3C: m_ehi = bus_wdata[15:0];
                    default: ;
                endcase
            end
            m_st = (m_st & ~clr) | ev;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live && !rst) begin
            chk("R9 irq vs model", {31'h0, irq}, {31'h0, m_irq});
            chk("R10 pad_oe vs model", {16'h0, pad_oe}, {16'h0, ~m_dir});
            chk("R10 pad_out vs model", {16'h0, pad_out}, {16'h0, m_dout & ~m_dir});
            chk({m_rtag, " rdata vs model"}, bus_rdata, m_rdata);
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk); bus_addr = a; bus_re = 1'b1; cur_tag = tag;
        @(negedge clk); bus_re = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        live = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
        rd(8'h1C, 32'h0, "R1 enable");
        rd(8'h34, 32'hFFFF, "R1 direction");
        rd(8'h18, 32'h0, "R1 status");
        rd(8'h30, 32'h0, "R1 dout");
        rd(8'h38, 32'h0, "R1 edge lo");
        // R2 revision and unmapped
        rd(8'h00, 32'h21, "R2 revision");
        rd(8'h04, 32'h0, "R2 unmapped");
        // R3 direct registers, R10 pad drive
        wr(8'h34, 32'hABCD_00FF);
        wr(8'h30, 32'h0000_1234);
        chk("R10 pad_oe", {16'h0, pad_oe}, 32'hFF00);
        chk("R10 pad_out", {16'h0, pad_out}, 32'h1200);
        rd(8'h30, 32'h1234, "R3 dout");
        rd(8'h34, 32'h00FF, "R3 direction upper bits dropped");
        // R4 aliases
        wr(8'hF0, 32'h0001);
        rd(8'h30, 32'h1235, "R4 set alias");
        wr(8'hB0, 32'h1200);
        rd(8'h30, 32'h0035, "R4 clear alias");
        chk("R10 pad_out after clear", {16'h0, pad_out}, 32'h0);
        // R5 enable aliases
        wr(8'h1C, 32'h0003);
        wr(8'hDC, 32'h0010);
        rd(8'h1C, 32'h0013, "R5 set alias");
        wr(8'h9C, 32'h0001);
        rd(8'h1C, 32'h0012, "R5 clear alias");
        // R6 edge layout: pin0 rise, pin1 fall, pin2 both, pin3 none, pin9 rise
        wr(8'h34, 32'hFFFF);
        wr(8'h38, 32'h0039);
        wr(8'h3C, 32'h0004);
        rd(8'h38, 32'h0039, "R3 edge lo");
        rd(8'h3C, 32'h0004, "R3 edge hi");
        wr(8'h18, 32'hFFFF);
        rd(8'h18, 32'h0, "R8 clear all");
        @(negedge clk); pad_in = 16'h020F;
        idle(4);
        rd(8'h18, 32'h0205, "R6 R7 rising edges");
        chk("R7 masked pins give no irq", {31'h0, irq}, 32'h0);
        @(negedge clk); pad_in = 16'h0000;
        idle(4);
        rd(8'h18, 32'h0207, "R6 falling and both");
        chk("R9 irq on enabled pin", {31'h0, irq}, 32'h1);
        // R8 write-one-to-clear
        wr(8'h18, 32'h0000);
        rd(8'h18, 32'h0207, "R8 zero write no effect");
        wr(8'h18, 32'h0002);
        rd(8'h18, 32'h0205, "R8 single clear");
        chk("R9 irq drops", {31'h0, irq}, 32'h0);
        wr(8'h18, 32'h0001);
        rd(8'h18, 32'h0204, "R8 clear pin0");
        // R8 set wins over a clear in the same cycle
        @(negedge clk); pad_in = 16'h0001;
        @(negedge clk);
        wr(8'h18, 32'h0001);
        rd(8'h18, 32'h0205, "R8 set wins");
        // R9 enabling a pending pin
        wr(8'hDC, 32'h0001);
        idle(1);
        chk("R9 irq after enable", {31'h0, irq}, 32'h1);
        // R10 data in regardless of direction
        wr(8'h34, 32'h000F);
        @(negedge clk); pad_in = 16'h0A05;
        idle(3);
        rd(8'h2C, 32'h0A05, "R10 data in");
        chk("R10 pad_oe outputs", {16'h0, pad_oe}, 32'hFFF0);
        chk("R10 pad_out outputs", {16'h0, pad_out}, 32'h0030);
        idle(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule